// File: doc/BRIEF.md
# Refresh Scheduler with Postponement

This block decides when a DRAM controller's command arbiter must send an AUTO REFRESH command. An interval timer counts a programmable number of clock cycles, which corresponds to the device's average refresh period of about 15.6 us. Each time the timer expires, the block adds one refresh to a debt counter. Each refresh that the arbiter acknowledges removes one refresh from that counter. The debt is bounded at eight. With at most eight refreshes owed, two consecutive refreshes are never more than nine intervals apart. That bound matters because the device updates its internal delay-locked loop only during refresh.

When traffic is busy, the arbiter may postpone refreshes. While the debt is below eight and the busy input is high, the block holds its normal request low. When the busy input drops and any debt remains, the block raises the normal request. It holds the request high for as long as the debt stays above zero, so an arbiter that acknowledges every cycle clears the whole backlog in a back-to-back burst. When the debt reaches eight, the block raises the urgent request whatever the busy input says. The arbiter must serve the urgent request ahead of every other command.

Top module: `refresh_debt_sched`

## Requirements
- R1: After reset the debt is 0, both request outputs are low and the interval timer restarts from zero.
- R2: With `cfg_interval` = N (N >= 1), the debt rises by one at the Nth rising clock edge after reset is released, and again every N edges after that. A value of 0 behaves like 1, which means one increment per edge.
- R3: An accepted acknowledge lowers the debt by one at the next edge. If an accepted acknowledge falls in the same cycle as a timer expiry, the debt is unchanged.
- R4: The debt never exceeds 8. A timer expiry while the debt is 8 and no acknowledge is accepted leaves the debt at 8.
- R5: `ref_req` is high exactly when the debt is between 1 and 7 and `traffic_busy` is low. A change of `traffic_busy` takes effect in the same cycle.
- R6: `ref_urgent` is high exactly when the debt is 8, whatever the level of `traffic_busy`. `ref_req` is low whenever `ref_urgent` is high.
- R7: An acknowledge is accepted only in a cycle where `ref_req` or `ref_urgent` is high. In any other cycle the acknowledge has no effect on the debt, which includes cycles where the debt is 0 and cycles where `traffic_busy` suppresses the request.
- R8: With `traffic_busy` low and the acknowledge held high, the debt falls by one on every edge until it reaches 0, and `ref_req` then drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_interval | input | CNT_W | Refresh interval in clock cycles |
| traffic_busy | input | 1 | High while the arbiter wants refreshes postponed |
| ref_ack | input | 1 | The arbiter issued a refresh this cycle |
| ref_req | output | 1 | Low-priority refresh request |
| ref_urgent | output | 1 | Debt at its limit: must be served before any other command |
| debt | output | DEBT_W | Number of refreshes owed (0 to MAX_DEBT) |

## Verification
The bench drives the saturation point: the debt must stop at eight and switch from the normal request to the urgent one. A counter that wrapped would show zero and drop every request, and a design that kept the normal request alongside the urgent one would give the arbiter two conflicting signals. The bench also places an acknowledge exactly in a cycle where the timer expires. A design that gave either event priority would then be off by one. It sends acknowledges at zero debt and while busy suppresses the request. A design that accepted them would underflow or silently drop a refresh that was owed. Finally, it checks the cycle of the first expiry at interval lengths of 0, 1, 4 and 5, which catches off-by-one errors in the timer compare.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        LVL_NONE   = 2'd0,
        LVL_NORMAL = 2'd1,
        LVL_URGENT = 2'd2
    } req_level_e;

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W:0] count_next;

    // Expire when the cycle now running is the last one of the period.
    assign count_next = {1'b0, st_q.count} + 1'b1;
    assign tick       = (count_next >= {1'b0, period});

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.count = '0;
        end else begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an expiry restarts the period
    assert_timer_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.count == '0));

    // R2: without expiry the timer advances by exactly one
    assert_timer_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (st_q.count == $past(st_q.count) + 1'b1));

endmodule

// File: rtl/refresh_debt_counter.sv
module refresh_debt_counter #(
    parameter int MAX_DEBT = 8,
    parameter int DEBT_W   = $clog2(MAX_DEBT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              accept,
    output logic [DEBT_W-1:0] debt
);

    localparam logic [DEBT_W-1:0] DEBT_LIMIT = DEBT_W'(MAX_DEBT);

    typedef struct packed {
        logic [DEBT_W-1:0] owed;
    } debt_state_t;

    debt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case ({tick, accept})
            2'b10: begin
                if (st_q.owed < DEBT_LIMIT) begin
                    st_d.owed = st_q.owed + 1'b1;
                end
            end
            2'b01: begin
                if (st_q.owed != '0) begin
                    st_d.owed = st_q.owed - 1'b1;
                end
            end
            default: st_d = st_q;   // idle, or expiry and refresh cancel out
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign debt = st_q.owed;

    // R4: the debt stays within its bound
    assert_debt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.owed <= DEBT_LIMIT);

    // R3: a lone accepted refresh pays one off
    assert_ack_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !tick && st_q.owed != '0) |=> (st_q.owed == $past(st_q.owed) - 1'b1));

    // R3: expiry plus refresh in one cycle leaves the debt unchanged
    assert_cancel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tick) |=> $stable(st_q.owed));

    // R2: a lone expiry below the limit adds one
    assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !accept && st_q.owed < DEBT_LIMIT) |=> (st_q.owed == $past(st_q.owed) + 1'b1));

endmodule

// File: rtl/refresh_request_logic.sv
module refresh_request_logic
    import refresh_pkg::*;
#(
    parameter int MAX_DEBT = 8,
    parameter int DEBT_W   = $clog2(MAX_DEBT + 1)
) (
    input  logic [DEBT_W-1:0] debt,
    input  logic              busy,
    output logic              req_normal,
    output logic              req_urgent
);

    localparam logic [DEBT_W-1:0] DEBT_LIMIT = DEBT_W'(MAX_DEBT);

    req_level_e level;

    always_comb begin
        if (debt >= DEBT_LIMIT) begin
            level = LVL_URGENT;
        end else if ((debt != '0) && !busy) begin
            level = LVL_NORMAL;
        end else begin
            level = LVL_NONE;
        end
    end

    assign req_normal = (level == LVL_NORMAL);
    assign req_urgent = (level == LVL_URGENT);

endmodule

// File: rtl/refresh_debt_sched.sv
module refresh_debt_sched #(
    parameter int CNT_W    = 16,
    parameter int MAX_DEBT = 8,
    parameter int DEBT_W   = $clog2(MAX_DEBT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic              traffic_busy,
    input  logic              ref_ack,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic [DEBT_W-1:0] debt
);

    localparam logic [DEBT_W-1:0] DEBT_LIMIT = DEBT_W'(MAX_DEBT);

    logic tick;
    logic accept;

    refresh_interval_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (cfg_interval),
        .tick   (tick)
    );

    refresh_request_logic #(
        .MAX_DEBT (MAX_DEBT),
        .DEBT_W   (DEBT_W)
    ) u_req (
        .debt       (debt),
        .busy       (traffic_busy),
        .req_normal (ref_req),
        .req_urgent (ref_urgent)
    );

    // A grant counts only against a request that is actually showing.
    assign accept = ref_ack && (ref_req || ref_urgent);

    refresh_debt_counter #(
        .MAX_DEBT (MAX_DEBT),
        .DEBT_W   (DEBT_W)
    ) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .accept (accept),
        .debt   (debt)
    );

    // R7: with no request showing and no expiry, the debt holds
    assert_ignore_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_req && !ref_urgent && !tick) |=> $stable(debt));

    // R6: urgent excludes normal and marks a full debt
    assert_urgent_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (!ref_req && debt == DEBT_LIMIT));

    // R5: busy suppresses the normal request
    assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        traffic_busy |-> !ref_req);

    // R1: outputs quiet in the first cycle after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (debt == '0 && !ref_req && !ref_urgent));

endmodule

// File: tb/refresh_debt_sched_test.sv
module refresh_debt_sched_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int DEBT_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cfg_interval = 16'd1000;
    logic              traffic_busy = 1'b1;
    logic              ref_ack = 1'b0;
    logic              ref_req;
    logic              ref_urgent;
    logic [DEBT_W-1:0] debt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    refresh_debt_sched uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .traffic_busy (traffic_busy),
        .ref_ack      (ref_ack),
        .ref_req      (ref_req),
        .ref_urgent   (ref_urgent),
        .debt         (debt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // advance n rising edges, return at the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input int ival);
        cfg_interval = CNT_W'(ival);
        ref_ack      = 1'b0;
        rst_n        = 1'b0;
        step(3);
        rst_n        = 1'b1;
    endtask

    task automatic test_reset_state;
        do_reset(1000);
        chk("R1 debt after reset", int'(debt), 0);
        chk("R1 ref_req after reset", int'(ref_req), 0);
        chk("R1 ref_urgent after reset", int'(ref_urgent), 0);
    endtask

    task automatic test_interval_busy;
        traffic_busy = 1'b1;
        do_reset(5);
        step(4);
        chk("R2 debt before 5th edge", int'(debt), 0);
        step(1);
        chk("R2 debt at 5th edge", int'(debt), 1);
        step(5);
        chk("R2 debt at 10th edge", int'(debt), 2);
        chk("R5 ref_req low while busy", int'(ref_req), 0);
        ref_ack = 1'b1;
        step(1);
        ref_ack = 1'b0;
        chk("R7 ack ignored while busy", int'(debt), 2);
        traffic_busy = 1'b0;
        #1;
        chk("R5 ref_req same cycle busy drops", int'(ref_req), 1);
        traffic_busy = 1'b1;
    endtask

    task automatic test_short_intervals;
        traffic_busy = 1'b1;
        do_reset(1);
        step(3);
        chk("R2 interval 1 counts each edge", int'(debt), 3);
        do_reset(0);
        step(2);
        chk("R2 interval 0 acts as 1", int'(debt), 2);
    endtask

    task automatic test_saturate_and_drain;
        traffic_busy = 1'b1;
        do_reset(2);
        step(20);
        chk("R4 debt saturates at 8", int'(debt), 8);
        chk("R6 urgent at full debt", int'(ref_urgent), 1);
        chk("R6 normal low at full debt", int'(ref_req), 0);
        traffic_busy = 1'b0;
        #1;
        chk("R6 normal low when idle and full", int'(ref_req), 0);
        chk("R6 urgent stays when idle", int'(ref_urgent), 1);
        cfg_interval = 16'd1000;
        ref_ack = 1'b1;
        step(1);
        ref_ack = 1'b0;
        chk("R3 ack on urgent pays one", int'(debt), 7);
        chk("R6 urgent drops below 8", int'(ref_urgent), 0);
        chk("R5 normal after urgent cleared", int'(ref_req), 1);
        traffic_busy = 1'b1;
        ref_ack = 1'b1;
        step(1);
        ref_ack = 1'b0;
        chk("R7 ack ignored when suppressed", int'(debt), 7);
        traffic_busy = 1'b0;
        ref_ack = 1'b1;
        step(3);
        chk("R8 burst drains one per edge", int'(debt), 4);
        step(4);
        chk("R8 burst reaches zero", int'(debt), 0);
        chk("R8 ref_req drops at zero", int'(ref_req), 0);
        step(1);
        ref_ack = 1'b0;
        chk("R7 ack at zero debt ignored", int'(debt), 0);
        do_reset(1000);
        chk("R1 reset clears debt mid-run", int'(debt), 0);
    endtask

    task automatic test_tick_and_ack;
        traffic_busy = 1'b0;
        do_reset(4);
        step(7);
        chk("R2 debt one before second expiry", int'(debt), 1);
        chk("R5 ref_req with debt and idle", int'(ref_req), 1);
        ref_ack = 1'b1;
        step(1);
        ref_ack = 1'b0;
        chk("R3 expiry and ack cancel", int'(debt), 1);
        step(3);
        chk("R3 later expiry still counts", int'(debt), 1);
        ref_ack = 1'b1;
        step(1);
        ref_ack = 1'b0;
        chk("R3 cancel on next expiry", int'(debt), 1);
        step(1);
        chk("R3 steady after cancel", int'(debt), 1);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        test_reset_state();
        test_interval_busy();
        test_short_intervals();
        test_saturate_and_drain();
        test_tick_and_ack();
        done = 1'b1;
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            finish_run();
        end
    end

endmodule